// File: doc/BRIEF.md
# Serial CRC-5 Generator with Selectable LFSR Form

This block computes a 5-bit cyclic redundancy check over a bit stream presented one bit per cycle, most significant bit first. The generator polynomial is x^5 + x^2 + x + 1. Two shift-register structures can be selected per message, and both yield the same remainder.

In the direct form, the incoming bit is folded into the feedback. The remainder is ready after one shift per message bit. In the augmented form, message bits enter the low end of the register and the bit that leaves the top decides the feedback, as in long division. This form needs five zero bits after the message, and the block inserts those padding shifts itself.

A caller pulses `clear_i` with the wanted mode, streams bits with `valid_i`, and flags the final bit with `last_i`. It then waits for the one-cycle `done_o` pulse and reads `crc_o`. That value holds until the next clear.

Top module: `crc5_serial_gen`

## Requirements
- R1: With generator coefficients 100111 (highest power first), the message 10010011 sent MSB first yields `crc_o` = 01010 in both modes.
- R2: `clear_i` has priority over all other inputs. It zeroes `crc_o` at the next edge and aborts any message in progress, including one in the padding phase.
- R3: In direct mode (`mode_i` = 0), every accepted bit causes exactly one shift. `done_o` is high in the cycle right after the edge that accepted the bit marked by `last_i`.
- R4: In augmented mode (`mode_i` = 1), the block runs five zero-bit shifts on its own after the marked bit. `done_o` is high in the cycle after the fifth edge following the edge that accepted the marked bit.
- R5: For every message of 1 to 64 bits, both modes return the remainder of the message times x^5 divided modulo 2 by the generator.
- R6: `done_o` is a single-cycle pulse.
- R7: After `done_o`, `crc_o` keeps its value until the next `clear_i`, whatever arrives on `valid_i`, `bit_i` and `last_i`.
- R8: During the message phase, a cycle with `valid_i` low has no effect, whatever `bit_i` and `last_i` carry.
- R9: Inputs with `valid_i` high that arrive during the padding shifts are ignored.
- R10: `mode_i` is sampled only on a `clear_i` cycle. Changes to it later in the message have no effect.
- R11: After reset and before the first `clear_i`, data inputs are ignored and `crc_o` stays zero.
- R12: While `rst_ni` is low, `crc_o` is zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear and start of a message; samples the mode |
| mode_i | input | 1 | 0 = direct form, 1 = augmented form |
| bit_i | input | 1 | Serial message bit, MSB first |
| valid_i | input | 1 | Qualifies bit_i |
| last_i | input | 1 | Marks the final message bit (with valid_i) |
| crc_o | output | WIDTH | Remainder register |
| done_o | output | 1 | One-cycle pulse when the remainder is final |

## Verification
The bench builds the block with its default parameters: a width of 5 and low taps 00111. These are the values for which the known 10010011 vector and the bench's long-division model apply. With those defaults, random messages of up to 64 bits, with idle gaps and spurious markers, exercise both forms. Padding-phase noise, mid-message mode changes and aborted messages test the exact done latency of each form and the hold behaviour that follows it.

// File: rtl/crc5_pkg.sv
package crc5_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_PAD  = 2'd2,
    ST_DONE = 2'd3
  } crc_state_e;
endpackage

// File: rtl/crc5_step.sv
// One LFSR step; both forms computed, mode picks the result.
module crc5_step #(
  parameter int unsigned          WIDTH = 5,
  parameter logic [WIDTH-1:0]     TAPS  = 5'b00111
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             bit_i,
  input  logic             aug_i,
  output logic [WIDTH-1:0] nxt_o
);
  logic             fb_dir;
  logic             fb_aug;
  logic [WIDTH-1:0] nxt_dir;
  logic [WIDTH-1:0] nxt_aug;

  assign fb_dir = cur_i[WIDTH-1] ^ bit_i;
  assign fb_aug = cur_i[WIDTH-1];

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign nxt_dir[i] = TAPS[i] & fb_dir;
      assign nxt_aug[i] = bit_i ^ (TAPS[i] & fb_aug);
    end else begin : g_up
      assign nxt_dir[i] = cur_i[i-1] ^ (TAPS[i] & fb_dir);
      assign nxt_aug[i] = cur_i[i-1] ^ (TAPS[i] & fb_aug);
    end
  end

  assign nxt_o = aug_i ? nxt_aug : nxt_dir;
endmodule

// File: rtl/crc5_ctrl.sv
module crc5_ctrl
  import crc5_pkg::*;
#(
  parameter int unsigned WIDTH = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       mode_i,
  input  logic       valid_i,
  input  logic       last_i,
  output logic       zero_o,
  output logic       shift_o,
  output logic       pad_o,
  output logic       aug_o,
  output logic       done_o,
  output crc_state_e state_o
);
  localparam int unsigned CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] PAD_LAST = CW'(WIDTH - 1);

  crc_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          aug_q, aug_d;
  logic          done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    aug_d   = aug_q;
    done_d  = 1'b0;
    shift_o = 1'b0;
    pad_o   = 1'b0;
    zero_o  = 1'b0;
    if (clear_i) begin
      zero_o  = 1'b1;
      state_d = ST_RUN;
      aug_d   = mode_i;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_RUN: begin
          if (valid_i) begin
            shift_o = 1'b1;
            if (last_i) begin
              if (aug_q) begin
                state_d = ST_PAD;
                cnt_d   = '0;
              end else begin
                state_d = ST_DONE;
                done_d  = 1'b1;
              end
            end
          end
        end
        ST_PAD: begin
          shift_o = 1'b1;
          pad_o   = 1'b1;
          cnt_d   = cnt_q + 1'b1;
          if (cnt_q == PAD_LAST) begin
            state_d = ST_DONE;
            done_d  = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      aug_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      aug_q   <= aug_d;
      done_q  <= done_d;
    end
  end

  assign aug_o   = aug_q;
  assign done_o  = done_q;
  assign state_o = state_q;

  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);

  p_direct_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && valid_i && last_i && !aug_q && !clear_i) |=> done_q);

  p_mode_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> $stable(aug_q));

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !clear_i) |=> (state_q == ST_IDLE && !done_q));
endmodule

// File: rtl/crc5_reg.sv
module crc5_reg #(
  parameter int unsigned WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  input  logic             shift_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] crc_o
);
  logic [WIDTH-1:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= '0;
    else if (zero_i)  crc_q <= '0;
    else if (shift_i) crc_q <= nxt_i;
  end

  assign crc_o = crc_q;

  p_clear_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_i |=> (crc_q == '0));

  p_no_shift_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!zero_i && !shift_i) |=> $stable(crc_q));
endmodule

// File: rtl/crc5_serial_gen.sv
module crc5_serial_gen
  import crc5_pkg::*;
#(
  parameter int unsigned      WIDTH = 5,
  parameter logic [WIDTH-1:0] TAPS  = 5'b00111
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             mode_i,
  input  logic             bit_i,
  input  logic             valid_i,
  input  logic             last_i,
  output logic [WIDTH-1:0] crc_o,
  output logic             done_o
);
  localparam int unsigned CW = $clog2(WIDTH + 1);

  logic             zero, shift, pad, aug;
  logic             step_bit;
  logic [WIDTH-1:0] nxt;
  crc_state_e       state;

  crc5_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear_i),
    .mode_i  (mode_i),
    .valid_i (valid_i),
    .last_i  (last_i),
    .zero_o  (zero),
    .shift_o (shift),
    .pad_o   (pad),
    .aug_o   (aug),
    .done_o  (done_o),
    .state_o (state)
  );

  // padding shifts feed zeros
  assign step_bit = pad ? 1'b0 : bit_i;

  crc5_step #(.WIDTH(WIDTH), .TAPS(TAPS)) u_step (
    .cur_i (crc_o),
    .bit_i (step_bit),
    .aug_i (aug),
    .nxt_o (nxt)
  );

  crc5_reg #(.WIDTH(WIDTH)) u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .zero_i  (zero),
    .shift_i (shift),
    .nxt_i   (nxt),
    .crc_o   (crc_o)
  );

  // count zero shifts seen after the marked bit, for the padding-length check
  logic [CW-1:0] pad_seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pad_seen_q <= '0;
    else if (clear_i) pad_seen_q <= '0;
    else if (state == ST_RUN && valid_i && last_i) pad_seen_q <= '0;
    else if (state == ST_PAD) pad_seen_q <= pad_seen_q + 1'b1;
  end

  p_aug_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && aug) |-> (pad_seen_q == CW'(WIDTH)));

  p_hold_after_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_DONE && !clear_i) |=> $stable(crc_o));

  p_pad_ignores_in_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_PAD && !clear_i) |-> (shift && pad));
endmodule

// File: tb/crc5_serial_gen_tb.sv
module crc5_serial_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clear = 1'b0;
  logic       mode = 1'b0;
  logic       bit_in = 1'b0;
  logic       valid = 1'b0;
  logic       last = 1'b0;
  logic [4:0] crc;
  logic       done;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  crc5_serial_gen dut_i (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .clear_i (clear),
    .mode_i  (mode),
    .bit_i   (bit_in),
    .valid_i (valid),
    .last_i  (last),
    .crc_o   (crc),
    .done_o  (done)
  );

  localparam int unsigned NV = 6;
  localparam int unsigned VLEN [NV] = '{8, 1, 5, 16, 64, 33};
  localparam logic [63:0] VMSG [NV] = '{
    64'h93, 64'h1, 64'h15, 64'hBEEF, 64'hDEAD_BEEF_0123_4567, 64'h1_8000_0001
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] model(input int unsigned len, input logic [63:0] msg);
    logic [5:0] r = '0;
    for (int k = 0; k < int'(len) + 5; k++) begin
      r = {r[4:0], (k < int'(len)) ? msg[int'(len) - 1 - k] : 1'b0};
      if (r[5]) r = r ^ 6'b100111;
    end
    return r[4:0];
  endfunction

  // drives at negedges; returns crc at done and crc after hold window
  task automatic run_msg(input logic m, input int unsigned len, input logic [63:0] msg,
                         input bit gaps, input bit noise, input bit flip,
                         output logic [4:0] at_done, output logic [4:0] later);
    int lat;
    int got_at;
    bit twice;
    @(negedge clk);
    clear = 1'b1; mode = m; valid = 1'b0; last = 1'b0;
    @(negedge clk);
    clear = 1'b0;
    if (flip) mode = ~m;
    for (int i = int'(len) - 1; i >= 0; i--) begin
      if (gaps && ($urandom % 3 == 0)) begin
        valid = 1'b0; bit_in = 1'($urandom); last = 1'($urandom);
        @(negedge clk);
      end
      valid = 1'b1; bit_in = msg[i]; last = (i == 0);
      @(negedge clk);
    end
    lat = m ? 6 : 1;
    got_at = 0; twice = 0; at_done = 'x;
    for (int k = 1; k <= 9; k++) begin
      if (done) begin
        if (got_at == 0) got_at = k; else twice = 1;
      end
      if (k == lat) at_done = crc;
      valid = noise; bit_in = 1'($urandom); last = 1'($urandom);
      if (flip) mode = 1'($urandom);
      @(negedge clk);
    end
    later = crc;
    valid = 1'b0; last = 1'b0;
    if (m) check(got_at == lat && !twice, "R4 done latency", got_at, lat);
    else   check(got_at == lat && !twice, "R3 done latency", got_at, lat);
    check(!twice, "R6 single pulse", int'(twice), 0);
  endtask

  initial begin
    logic [4:0] a, b, e;
    repeat (3) @(negedge clk);
    check(crc == 5'd0 && done == 1'b0, "R12 reset state", {done, crc}, 0);
    rst_n = 1'b1;
    // R11: no clear yet, inputs ignored
    for (int i = 0; i < 6; i++) begin
      valid = 1'b1; bit_in = 1'b1; last = (i == 5);
      @(negedge clk);
    end
    check(crc == 5'd0 && done == 1'b0, "R11 pre-clear quiet", {done, crc}, 0);
    valid = 1'b0; last = 1'b0;

    // R1 known vector, both forms
    run_msg(1'b0, 8, 64'h93, 0, 0, 0, a, b);
    check(a == 5'b01010, "R1 direct 10010011", a, 5'b01010);
    run_msg(1'b1, 8, 64'h93, 0, 0, 0, a, b);
    check(a == 5'b01010, "R1 augmented 10010011", a, 5'b01010);

    // table walk, both modes
    for (int v = 0; v < int'(NV); v++) begin
      e = model(VLEN[v], VMSG[v]);
      for (int m = 0; m < 2; m++) begin
        run_msg(1'(m), VLEN[v], VMSG[v], 0, 0, 0, a, b);
        check(a == e, "R5 table vector", a, e);
      end
    end

    // R8 gaps, R9/R7 noise after marker, R10 mode wiggle
    for (int m = 0; m < 2; m++) begin
      run_msg(1'(m), 20, 64'hA_5C3E, 1, 0, 0, a, b);
      e = model(20, 64'hA_5C3E);
      check(a == e, "R8 idle cycles ignored", a, e);
      run_msg(1'(m), 13, 64'h1ACE, 0, 1, 0, a, b);
      e = model(13, 64'h1ACE);
      if (m == 1) check(a == e, "R9 pad inputs ignored", a, e);
      check(b == a, "R7 hold after done", b, a);
      run_msg(1'(m), 17, 64'h1_2345, 0, 0, 1, a, b);
      e = model(17, 64'h1_2345);
      check(a == e, "R10 mode changes ignored", a, e);
    end

    // R2 clear aborts mid-message and mid-padding
    @(negedge clk); clear = 1'b1; mode = 1'b0;
    @(negedge clk); clear = 1'b0;
    for (int i = 0; i < 4; i++) begin valid = 1'b1; bit_in = 1'b1; last = 1'b0; @(negedge clk); end
    valid = 1'b0; clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    check(crc == 5'd0, "R2 clear zeroes", crc, 0);
    mode = 1'b1;
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    for (int i = 0; i < 3; i++) begin valid = 1'b1; bit_in = 1'b1; last = (i == 2); @(negedge clk); end
    valid = 1'b0; last = 1'b0;
    @(negedge clk); @(negedge clk);
    clear = 1'b1; mode = 1'b0;
    @(negedge clk); clear = 1'b0;
    check(crc == 5'd0 && done == 1'b0, "R2 clear in padding", {done, crc}, 0);
    repeat (6) @(negedge clk);
    check(done == 1'b0, "R2 aborted pad no done", done, 0);
    run_msg(1'b0, 8, 64'h93, 0, 0, 0, a, b);
    check(a == 5'b01010, "R2 restart after abort", a, 5'b01010);

    // random messages, both modes
    for (int t = 0; t < 60; t++) begin
      int unsigned len;
      logic [63:0] msg;
      len = 1 + ($urandom % 64);
      msg = {$urandom, $urandom};
      e = model(len, msg);
      run_msg(1'(t % 2), len, msg, 1'($urandom), 1'($urandom), 0, a, b);
      check(a == e, "R5 random message", a, e);
      check(b == a, "R7 random hold", b, a);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule